// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Selector

This block holds the digital dividers around a frequency-synthesizer loop, together with the selector that drives a test pin. It divides a reference clock by a fixed 16 to give the reference input of the phase comparator. It divides the oscillator-rate clock by a programmable 9-bit ratio to give the feedback input. It also divides the oscillator-rate clock by 1, 2, 4 or 8 to give the differential main output. The phase comparator, the loop filter and the oscillator itself lie outside the block. Here the oscillator-rate clock is an ordinary input clock.

The configuration logic supplies the feedback ratio, the output-divider code and the test code, and these may change while the clocks run. A ratio change waits for the end of the running feedback count. An output-divider change waits for the wrap of the output counter, and division by 1 goes through a glitch-free clock switch. The output-enable input passes through a two-stage synchronizer clocked on the falling edge of the output clock. Because of these three measures, no reconfiguration and no enable change can cut an output pulse short. The test pin can show any one of eight internal signals, which lets the loop's dividers be observed on a tester.

Top module: `synth_div_chain`

## Requirements
- R1: While rst_ni is low, fb_ref_o, fb_vco_o and fout_o are 0 and fout_n_o is 1.
- R2: fb_ref_o has a period of 16 ref_clk_i cycles and stays high for 8 of them.
- R3: fb_vco_o has a period of M vco_clk_i cycles, with M = m_i, and stays high for exactly one vco_clk_i cycle in each period. Values of m_i below 2 act as 2.
- R4: A new m_i takes effect only at the end of the count in progress. The period that is running when m_i changes keeps the old length.
- R5: The output-divider code n_i = 00, 01, 10, 11 divides vco_clk_i by 1, 2, 4, 8 respectively. The output has a 50% duty cycle for every code.
- R6: A change of n_i while running takes effect at the wrap of the output counter. No high or low phase of fout_o is shorter than half the shorter of the old and new output periods.
- R7: While the synchronized enable is low, fout_o is 0 and fout_n_o is 1. Enabling or disabling never yields an fout_o high phase shorter than half the output period.
- R8: test_o follows sdo_i for t_i = 000, is constant 1 for t_i = 001 and is constant 0 for t_i = 101.
- R9: test_o is fb_ref_o for t_i = 010, fb_vco_o for t_i = 011 and fout_o for t_i = 100.
- R10: test_o is sclk_i divided by M, with a high phase of one sclk_i cycle, for t_i = 110. It is the ungated output clock divided by 4, with 50% duty, for t_i = 111.
- R11: fout_n_o is always the inverse of fout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock |
| vco_clk_i | input | 1 | Oscillator-rate clock |
| sclk_i | input | 1 | Serial shift clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_i | input | 9 | Feedback division ratio |
| n_i | input | 2 | Output-divider code |
| t_i | input | 3 | Test-pin source select |
| oe_i | input | 1 | Output enable, asynchronous |
| sdo_i | input | 1 | Serial-out bit of the configuration shift register |
| fb_ref_o | output | 1 | Reference divided by 16 |
| fb_vco_o | output | 1 | Oscillator-rate clock divided by M |
| fout_o | output | 1 | Main output, true side |
| fout_n_o | output | 1 | Main output, complement side |
| test_o | output | 1 | Test pin |

## Verification
Suppose the feedback counter reloads from the wrong value or latches the ratio early. The next fb_vco_o period then has the wrong length, and the bench measures this within one or two periods, even for a ratio of 511. An output counter or select register that updates at the wrong time, or a bypass enable that switches while the oscillator clock is high, produces a runt phase on fout_o. The edge-width monitor catches such a runt the moment it appears. A faulty enable synchronizer shows either as a truncated first or last pulse or as fout_o still toggling several cycles after the disable.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int unsigned M_W = 9;
  localparam int unsigned N_W = 2;
  localparam int unsigned T_W = 3;

  typedef enum logic [T_W-1:0] {
    TSEL_SDO  = 3'd0,
    TSEL_HIGH = 3'd1,
    TSEL_REF  = 3'd2,
    TSEL_FBK  = 3'd3,
    TSEL_OUT  = 3'd4,
    TSEL_LOW  = 3'd5,
    TSEL_SCLK = 3'd6,
    TSEL_OUT4 = 3'd7
  } tsel_e;
endpackage

// File: rtl/sd_pow2_div.sv
module sd_pow2_div #(
  parameter int unsigned LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic div_o
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // MSB of a free-running binary counter: exact 50% duty
  assign div_o = cnt_q[LOG2-1];
endmodule

// File: rtl/sd_mod_div.sv
module sd_mod_div #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  localparam logic [W-1:0] MIN_RATIO = W'(2);

  logic [W-1:0] cnt_q;
  logic [W-1:0] ratio_eff;
  logic         pulse_q;

  assign ratio_eff = (ratio_i < MIN_RATIO) ? MIN_RATIO : ratio_i;

  // ratio is sampled only at terminal count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (cnt_q == '0);
      if (cnt_q == '0) cnt_q <= ratio_eff - W'(1);
      else             cnt_q <= cnt_q - W'(1);
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sd_out_div.sv
module sd_out_div #(
  parameter int unsigned N_W = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] sel_i,
  input  logic           oe_i,
  output logic           clk_o,
  output logic           fout_o
);
  localparam int unsigned CODES = 1 << N_W;
  localparam int unsigned CNT_W = CODES - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [N_W-1:0]   sel_q;
  logic [CODES-1:0] taps;
  logic             div_sel;
  logic             bypass_q;
  logic             out_clk;
  logic             oe_meta_q;
  logic             oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) sel_q <= sel_i;  // switch only where every tap falls to 0
    end
  end

  assign taps[0] = 1'b0;
  for (genvar k = 1; k < CODES; k++) begin : g_tap
    assign taps[k] = cnt_q[k-1];
  end

  assign div_sel = taps[sel_q];

  // bypass enable moves only while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bypass_q <= 1'b0;
    else         bypass_q <= (sel_q == '0);
  end

  assign out_clk = (clk_i & bypass_q) | (div_sel & ~bypass_q);

  always_ff @(negedge out_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_meta_q <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      oe_meta_q <= oe_i;
      oe_q      <= oe_meta_q;
    end
  end

  assign clk_o  = out_clk;
  assign fout_o = out_clk & oe_q;
endmodule

// File: rtl/sd_test_mux.sv
module sd_test_mux
  import synth_div_pkg::*;
(
  input  tsel_e sel_i,
  input  logic  sdo_i,
  input  logic  ref_div_i,
  input  logic  fbk_div_i,
  input  logic  fout_i,
  input  logic  sclk_div_i,
  input  logic  fout_div4_i,
  output logic  test_o
);
  always_comb begin
    unique case (sel_i)
      TSEL_SDO:  test_o = sdo_i;
      TSEL_HIGH: test_o = 1'b1;
      TSEL_REF:  test_o = ref_div_i;
      TSEL_FBK:  test_o = fbk_div_i;
      TSEL_OUT:  test_o = fout_i;
      TSEL_LOW:  test_o = 1'b0;
      TSEL_SCLK: test_o = sclk_div_i;
      TSEL_OUT4: test_o = fout_div4_i;
      default:   test_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int unsigned REF_LOG2  = 4,
  parameter int unsigned POST_LOG2 = 2
) (
  input  logic           ref_clk_i,
  input  logic           vco_clk_i,
  input  logic           sclk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic [T_W-1:0] t_i,
  input  logic           oe_i,
  input  logic           sdo_i,
  output logic           fb_ref_o,
  output logic           fb_vco_o,
  output logic           fout_o,
  output logic           fout_n_o,
  output logic           test_o
);
  logic ref_div;
  logic fbk_div;
  logic sclk_div;
  logic out_clk;
  logic fout;
  logic fout_div4;

  sd_pow2_div #(.LOG2(REF_LOG2)) u_ref (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .div_o (ref_div)
  );

  sd_mod_div #(.W(M_W)) u_fbk (
    .clk_i  (vco_clk_i),
    .rst_ni (rst_ni),
    .ratio_i(m_i),
    .pulse_o(fbk_div)
  );

  sd_mod_div #(.W(M_W)) u_sdiv (
    .clk_i  (sclk_i),
    .rst_ni (rst_ni),
    .ratio_i(m_i),
    .pulse_o(sclk_div)
  );

  sd_out_div #(.N_W(N_W)) u_out (
    .clk_i (vco_clk_i),
    .rst_ni(rst_ni),
    .sel_i (n_i),
    .oe_i  (oe_i),
    .clk_o (out_clk),
    .fout_o(fout)
  );

  sd_pow2_div #(.LOG2(POST_LOG2)) u_post (
    .clk_i (out_clk),
    .rst_ni(rst_ni),
    .div_o (fout_div4)
  );

  sd_test_mux u_tmux (
    .sel_i      (tsel_e'(t_i)),
    .sdo_i      (sdo_i),
    .ref_div_i  (ref_div),
    .fbk_div_i  (fbk_div),
    .fout_i     (fout),
    .sclk_div_i (sclk_div),
    .fout_div4_i(fout_div4),
    .test_o     (test_o)
  );

  assign fb_ref_o = ref_div;
  assign fb_vco_o = fbk_div;
  assign fout_o   = fout;
  assign fout_n_o = ~fout;
endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk (
  input logic       ref_clk_i,
  input logic       vco_clk_i,
  input logic       rst_ni,
  input logic [2:0] t_i,
  input logic       sdo_i,
  input logic       fb_ref_o,
  input logic       fb_vco_o,
  input logic       test_o
);
  assert_fb_single_cycle_R3: assert property (
    @(posedge vco_clk_i) disable iff (!rst_ni) fb_vco_o |=> !fb_vco_o);

  assert_ref_high_holds_R2: assert property (
    @(posedge ref_clk_i) disable iff (!rst_ni) $rose(fb_ref_o) |=> fb_ref_o);

  assert_test_high_R8: assert property (
    @(posedge vco_clk_i) disable iff (!rst_ni) (t_i == 3'b001) |-> test_o);

  assert_test_low_R8: assert property (
    @(posedge vco_clk_i) disable iff (!rst_ni) (t_i == 3'b101) |-> !test_o);

  assert_test_sdo_R8: assert property (
    @(posedge vco_clk_i) disable iff (!rst_ni) (t_i == 3'b000) |-> (test_o == sdo_i));
endmodule

bind synth_div_chain synth_div_chain_chk u_chk (
  .ref_clk_i(ref_clk_i),
  .vco_clk_i(vco_clk_i),
  .rst_ni   (rst_ni),
  .t_i      (t_i),
  .sdo_i    (sdo_i),
  .fb_ref_o (fb_ref_o),
  .fb_vco_o (fb_vco_o),
  .test_o   (test_o)
);

// File: tb/tb_synth_div_chain.sv
`timescale 1ns/1ps
module tb_synth_div_chain;
  logic       ref_clk = 0, vco_clk = 0, sclk = 0, rst_n = 0;
  logic [8:0] m = 9'd5;
  logic [1:0] n = 2'd1;
  logic [2:0] t = 3'd0;
  logic       oe = 1, sdo = 0;
  logic       fb_ref, fb_vco, fout, fout_n, test_pin;

  int n_chk = 0, n_bad = 0;
  int probe_sel = 0;
  logic probe;
  real per, hi, t0, t1, t2;
  real last_t, min_hi, min_lo;
  bit  mon_en = 0, mon_first = 1;

  synth_div_chain dut (
    .ref_clk_i(ref_clk), .vco_clk_i(vco_clk), .sclk_i(sclk), .rst_ni(rst_n),
    .m_i(m), .n_i(n), .t_i(t), .oe_i(oe), .sdo_i(sdo),
    .fb_ref_o(fb_ref), .fb_vco_o(fb_vco), .fout_o(fout), .fout_n_o(fout_n),
    .test_o(test_pin)
  );

  initial forever #2.5 vco_clk = ~vco_clk;   // 200 MHz
  initial forever #10  ref_clk = ~ref_clk;
  initial forever #20  sclk    = ~sclk;

  always_comb begin
    case (probe_sel)
      1:       probe = fout;
      2:       probe = fb_vco;
      3:       probe = fb_ref;
      default: probe = test_pin;
    endcase
  end

  always @(fout) begin
    if (mon_en) begin
      if (!mon_first) begin
        if (fout) begin if ($realtime - last_t < min_lo) min_lo = $realtime - last_t; end
        else      begin if ($realtime - last_t < min_hi) min_hi = $realtime - last_t; end
      end
      mon_first = 0;
      last_t = $realtime;
    end
  end

  task automatic chk_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_real(string tag, real act, real exp);
    n_chk++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      n_bad++;
      $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
    end
  endtask

  task automatic chk_min(string tag, real act, real lim);
    n_chk++;
    if (act < lim - 0.01) begin
      n_bad++;
      $display("FAIL %s: actual %0.3f expected >= %0.3f", tag, act, lim);
    end
  endtask

  task automatic measure(int src, output real p, output real h);
    real a, b, c;
    probe_sel = src;
    #0.1;
    @(posedge probe);
    @(posedge probe); a = $realtime;
    @(negedge probe); b = $realtime;
    @(posedge probe); c = $realtime;
    p = c - a;
    h = b - a;
  endtask

  task automatic vco_wait(int k);
    repeat (k) @(posedge vco_clk);
  endtask

  task automatic mon_start();
    min_hi = 1.0e9; min_lo = 1.0e9; mon_first = 1; last_t = $realtime; mon_en = 1;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    vco_wait(10);
    #1.25;
    chk_bit("R1 fb_ref", fb_ref, 1'b0);
    chk_bit("R1 fb_vco", fb_vco, 1'b0);
    chk_bit("R1 fout", fout, 1'b0);
    chk_bit("R1 fout_n", fout_n, 1'b1);
    @(negedge vco_clk); rst_n = 1;
    vco_wait(100);

    // R2 reference divide by 16
    measure(3, per, hi);
    chk_real("R2 period", per, 320.0);
    chk_real("R2 high", hi, 160.0);
    t = 3'b010;
    measure(0, per, hi);
    chk_real("R9 ref via test", per, 320.0);

    // R3 feedback ratio sweep
    foreach (m[i]) ;
    for (int i = 0; i < 8; i++) begin
      logic [8:0] mv;
      int eff;
      case (i)
        0: mv = 9'd2;   1: mv = 9'd3;   2: mv = 9'd5;   3: mv = 9'd17;
        4: mv = 9'd200; 5: mv = 9'd511; 6: mv = 9'd0;   default: mv = 9'd1;
      endcase
      eff = (mv < 2) ? 2 : int'(mv);
      @(negedge vco_clk); m = mv;
      @(posedge fb_vco);
      measure(2, per, hi);
      chk_real($sformatf("R3 period m=%0d", mv), per, 5.0 * eff);
      chk_real($sformatf("R3 high m=%0d", mv), hi, 5.0);
    end

    // R4 ratio change waits for terminal count
    @(negedge vco_clk); m = 9'd200;
    @(posedge fb_vco); @(posedge fb_vco);
    t0 = $realtime;
    repeat (50) @(negedge vco_clk);
    m = 9'd3;
    @(posedge fb_vco); t1 = $realtime;
    @(posedge fb_vco); t2 = $realtime;
    chk_real("R4 old period kept", t1 - t0, 1000.0);
    chk_real("R4 new period", t2 - t1, 15.0);

    @(negedge vco_clk); m = 9'd5; t = 3'b011;
    @(posedge fb_vco);
    measure(0, per, hi);
    chk_real("R9 fbk via test period", per, 25.0);
    chk_real("R9 fbk via test high", hi, 5.0);

    // R5 output divider codes
    for (int k = 0; k < 4; k++) begin
      @(negedge vco_clk); n = 2'(k);
      vco_wait(40);
      measure(1, per, hi);
      chk_real($sformatf("R5 period n=%0d", k), per, 5.0 * (1 << k));
      chk_real($sformatf("R5 high n=%0d", k), hi, 2.5 * (1 << k));
    end

    @(negedge vco_clk); n = 2'd2; t = 3'b100;
    vco_wait(40);
    measure(0, per, hi);
    chk_real("R9 fout via test period", per, 20.0);

    // R10 shift-clock and post dividers
    @(negedge vco_clk); m = 9'd3; t = 3'b110;
    #600;
    measure(0, per, hi);
    chk_real("R10 sclk/M period", per, 120.0);
    chk_real("R10 sclk/M high", hi, 40.0);
    @(negedge vco_clk); n = 2'd1; t = 3'b111;
    vco_wait(40);
    measure(0, per, hi);
    chk_real("R10 fout/4 period", per, 40.0);
    chk_real("R10 fout/4 high", hi, 20.0);

    // R8 fixed and pass-through test codes
    @(negedge vco_clk); t = 3'b000;
    for (int i = 0; i < 6; i++) begin
      sdo = i[0];
      #1;
      chk_bit("R8 sdo pass", test_pin, sdo);
    end
    t = 3'b001;
    for (int i = 0; i < 3; i++) begin vco_wait(3); #1.25; chk_bit("R8 const high", test_pin, 1'b1); end
    t = 3'b101;
    for (int i = 0; i < 3; i++) begin vco_wait(3); #1.25; chk_bit("R8 const low", test_pin, 1'b0); end

    // R11 complement
    for (int i = 0; i < 8; i++) begin
      @(posedge vco_clk); #1.25;
      chk_bit("R11 complement", fout_n, ~fout);
    end

    // R6 divider change mid-run
    @(negedge vco_clk); n = 2'd3;
    vco_wait(40);
    mon_start();
    vco_wait(13); #1.25;
    n = 2'd1;
    vco_wait(60);
    mon_en = 0;
    chk_min("R6 min high", min_hi, 5.0);
    chk_min("R6 min low", min_lo, 5.0);
    measure(1, per, hi);
    chk_real("R6 new period", per, 10.0);

    // R7 enable synchronization
    @(negedge vco_clk); n = 2'd2;
    vco_wait(40);
    mon_start();
    #7.3 oe = 0;
    vco_wait(30);
    for (int i = 0; i < 4; i++) begin
      @(posedge vco_clk); #1.25;
      chk_bit("R7 off true", fout, 1'b0);
      chk_bit("R7 off compl", fout_n, 1'b1);
    end
    #3.1 oe = 1;
    vco_wait(30);
    mon_en = 0;
    chk_min("R7 min high", min_hi, 10.0);
    measure(1, per, hi);
    chk_real("R7 resumed period", per, 20.0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule